// File: doc/BRIEF.md
# Serial Configuration Bitstream Master

This block sends a stored configuration bitstream to a downstream programmable device. It uses a two-wire serial link: a clock line and a data line. The block divides the system clock down to the serial clock. It reads the stream MSB-first from a byte-wide memory read port. It presents each bit while the serial clock is low, so that the receiver samples it on the rising edge.

Three inputs steer the block:
- A power-on reset starts the block and arms a one-time power-on wait.
- An active-high output enable runs the stream while high and acts as an active-low reset while low.
- An active-low chip select pauses the stream while it is high, keeping the current bit position.

When the last bit of this device's share of the stream has been clocked out, an active-low cascade output hands the link to the next device in a chain. The serial clock is then parked low. The data line is then either driven high or released, depending on a parameter.

Top module: `cfg_stream_master`

## Requirements
- R1: After `por_n` is released, no rising serial-clock edge occurs for `POR_CYCLES` clock cycles, even with `oe` high and `cs_n` low. After that wait, streaming starts without further stimulus. While `por_n` is low, `dclk` is 0, `data_oe` is 0 and `casc_n` is 1.
- R2: A restart after an `oe`-low reset does not repeat the power-on wait. The first rising edge of `dclk` follows `oe` rising within `HALF_CYC`+4 cycles.
- R3: While streaming without pause, every high phase and every low phase of `dclk` lasts exactly `HALF_CYC` clock cycles.
- R4: Stream bit k is bit (7 - k mod 8) of the byte at address k/8, so bytes are sent MSB first. `data_out` holds that bit across the rising `dclk` edge that samples it and changes only after a falling edge.
- R5: `data_oe` is 1 in the second cycle after `oe` is high with `cs_n` low.
- R6: While `oe` is low, `dclk` is 0 from the next cycle onward and no rising edge occurs. In that state `casc_n` is 1 and `data_oe` is 0. The next start begins again at stream bit 0.
- R7: While `cs_n` is high during streaming, `dclk` keeps its level and makes no edges. After `cs_n` returns low, the stream continues with no bit lost or repeated.
- R8: `casc_n` falls in the same cycle as the rising `dclk` edge that carries bit `TOTAL_BITS`-1. It stays low until `oe` goes low.
- R9: After the final bit, `dclk` is held at 0 with no further edges. With `PARK_HIGH`=1, `data_oe`=1 and `data_out`=1. With `PARK_HIGH`=0, `data_oe`=0.
- R10: If `oe` is low at the clock edge where the final rising edge would occur, that edge does not happen, `casc_n` stays 1 and `dclk` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| oe | input | 1 | Output enable; low resets the stream position |
| cs_n | input | 1 | Active-low chip select; high pauses the stream |
| mem_addr | output | ADDR_W | Byte address of the bitstream store |
| mem_rdata | input | 8 | Byte read combinationally at `mem_addr` |
| dclk | output | 1 | Serial clock to the downstream device |
| data_out | output | 1 | Serial data value |
| data_oe | output | 1 | Drive enable for the serial data line |
| casc_n | output | 1 | Active-low handoff to the next chained device |

## Verification
The cascade handoff and the `oe` reset can fall in the same cycle: the edge that would carry the final bit and raise the handoff can coincide with `oe` being low. The bench counts the cycles from the last-but-one falling edge. It drops `oe` so that it is low exactly at the clock edge where the final rise is due. It judges the outcome at the ports: the rise count stops one short of the stream length, `casc_n` never falls, and `dclk` stays low. The parked data line is judged on two instances, one for each `PARK_HIGH` setting.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
   typedef enum logic [1:0] {
      ST_POWERUP = 2'd0,
      ST_IDLE    = 2'd1,
      ST_STREAM  = 2'd2,
      ST_DONE    = 2'd3
   } cfgm_state_e;
endpackage

// File: rtl/cfgm_por_timer.sv
// One-time power-on wait; only a true power-on reset re-arms it.
module cfgm_por_timer #(
   parameter int unsigned POR_CYCLES = 20_000_000
) (
   input  logic clk,
   input  logic por_n,
   output logic por_done
);
   localparam int unsigned CW = (POR_CYCLES > 1) ? $clog2(POR_CYCLES + 1) : 1;

   if (POR_CYCLES < 1) begin : g_bad_por
      $error("cfgm_por_timer: POR_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          done_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (cnt_q == CW'(POR_CYCLES - 1)) done_q <= 1'b1;
         else                              cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign por_done = done_q;

   // R1: once the wait is over it never comes back without power-on reset
   p_por_sticky_r1: assert property (@(posedge clk) disable iff (!por_n)
      done_q |=> done_q);
endmodule

// File: rtl/cfgm_dclk_gen.sv
// Serial clock divider: each phase lasts HALF_CYC system cycles.
module cfgm_dclk_gen #(
   parameter int unsigned HALF_CYC = 7
) (
   input  logic clk,
   input  logic por_n,
   input  logic clear,
   input  logic run,
   output logic dclk,
   output logic rise,
   output logic fall
);
   if (HALF_CYC < 1) begin : g_bad_half
      $error("cfgm_dclk_gen: HALF_CYC must be at least 1");
   end

   logic dclk_q;
   logic term;

   if (HALF_CYC == 1) begin : g_direct
      assign term = 1'b1;
   end else begin : g_count
      localparam int unsigned CW = $clog2(HALF_CYC);
      logic [CW-1:0] cnt_q;
      assign term = (cnt_q == CW'(HALF_CYC - 1));
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                cnt_q <= '0;
         else if (clear)            cnt_q <= '0;
         else if (run && term)      cnt_q <= '0;
         else if (run)              cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)               dclk_q <= 1'b0;
      else if (clear)           dclk_q <= 1'b0;
      else if (run && term)     dclk_q <= ~dclk_q;
   end

   assign dclk = dclk_q;
   assign rise = run && !clear && term && !dclk_q;
   assign fall = run && !clear && term &&  dclk_q;

   // R3: with more than one cycle per phase, a fresh high phase lasts past one cycle
   p_high_min_r3: assert property (@(posedge clk) disable iff (!por_n)
      (HALF_CYC > 1) && $rose(dclk_q) |=> (dclk_q || $past(clear)));
endmodule

// File: rtl/cfgm_bit_cursor.sv
// Stream position: byte address plus bit index within the byte.
module cfgm_bit_cursor #(
   parameter int unsigned TOTAL_BITS = 1_000_000,
   parameter int unsigned ADDR_W     = 17
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              clear,
   input  logic              step,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [2:0]        bit_sel,
   output logic              last
);
   localparam int unsigned PW = ADDR_W + 3;

   if (TOTAL_BITS < 1 || TOTAL_BITS > (64'd1 << PW)) begin : g_bad_len
      $error("cfgm_bit_cursor: TOTAL_BITS does not fit the address space");
   end

   logic [PW-1:0] ptr_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      ptr_q <= '0;
      else if (clear)  ptr_q <= '0;
      else if (step)   ptr_q <= ptr_q + 1'b1;
   end

   assign byte_addr = ptr_q[PW-1:3];
   assign bit_sel   = ptr_q[2:0];
   assign last      = (ptr_q == PW'(TOTAL_BITS - 1));

   // R4: the position never runs beyond the final bit
   p_cursor_bound_r4: assert property (@(posedge clk) disable iff (!por_n)
      ptr_q <= PW'(TOTAL_BITS - 1));
endmodule

// File: rtl/cfg_stream_master.sv
module cfg_stream_master
   import cfgm_pkg::*;
#(
   parameter int unsigned POR_CYCLES = 20_000_000,
   parameter int unsigned HALF_CYC   = 7,
   parameter int unsigned TOTAL_BITS = 1_000_000,
   parameter int unsigned ADDR_W     = 17,
   parameter bit          PARK_HIGH  = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              oe,
   input  logic              cs_n,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              dclk,
   output logic              data_out,
   output logic              data_oe,
   output logic              casc_n
);
   cfgm_state_e state_q, state_d;
   logic        por_done;
   logic        casc_q;
   logic        clk_clear, rise, fall;
   logic [2:0]  bit_sel;
   logic        last_bit;
   logic        park_oe, park_val;

   cfgm_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
      .clk      (clk),
      .por_n    (por_n),
      .por_done (por_done)
   );

   assign clk_clear = !oe || (state_q != ST_STREAM);

   cfgm_dclk_gen #(.HALF_CYC(HALF_CYC)) u_div (
      .clk   (clk),
      .por_n (por_n),
      .clear (clk_clear),
      .run   (!cs_n),
      .dclk  (dclk),
      .rise  (rise),
      .fall  (fall)
   );

   cfgm_bit_cursor #(.TOTAL_BITS(TOTAL_BITS), .ADDR_W(ADDR_W)) u_cur (
      .clk       (clk),
      .por_n     (por_n),
      .clear     (!oe),
      .step      (fall && !casc_q),
      .byte_addr (mem_addr),
      .bit_sel   (bit_sel),
      .last      (last_bit)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_POWERUP: if (por_done)           state_d = ST_IDLE;
         ST_IDLE:    if (oe && !cs_n)        state_d = ST_STREAM;
         ST_STREAM:  if (!oe)                state_d = ST_IDLE;
                     else if (fall && casc_q) state_d = ST_DONE;
         ST_DONE:    if (!oe)                state_d = ST_IDLE;
         default:                            state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= ST_POWERUP;
         casc_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (!oe)                   casc_q <= 1'b0;
         else if (rise && last_bit) casc_q <= 1'b1;
      end
   end

   if (PARK_HIGH) begin : g_park_drive
      assign park_oe  = 1'b1;
      assign park_val = 1'b1;
   end else begin : g_park_float
      assign park_oe  = 1'b0;
      assign park_val = 1'b0;
   end

   always_comb begin
      unique case (state_q)
         ST_STREAM: begin
            data_oe  = 1'b1;
            data_out = mem_rdata[3'd7 - bit_sel];
         end
         ST_DONE: begin
            data_oe  = park_oe;
            data_out = park_val;
         end
         default: begin
            data_oe  = 1'b0;
            data_out = 1'b0;
         end
      endcase
   end

   assign casc_n = ~casc_q;

   // R6: output enable low stops the serial clock and withdraws the handoff
   p_dclk_low_on_oe_r6: assert property (@(posedge clk) disable iff (!por_n)
      !oe |=> !dclk);
   p_casc_off_on_oe_r6: assert property (@(posedge clk) disable iff (!por_n)
      !oe |=> casc_n);
   // R7: a deselected stream freezes the serial clock
   p_pause_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == ST_STREAM) && oe && cs_n |=> $stable(dclk));
   // R8: the handoff appears together with a rising serial clock edge
   p_casc_on_rise_r8: assert property (@(posedge clk) disable iff (!por_n)
      $fell(casc_n) |-> $rose(dclk));
   // R9: once finished the clock is parked low with the handoff asserted
   p_done_parked_r9: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == ST_DONE) |-> (!dclk && !casc_n));
   // R4: the bit position is frozen while the serial clock is high
   p_stable_high_r4: assert property (@(posedge clk) disable iff (!por_n)
      dclk && $past(dclk) |-> ($stable(mem_addr) && $stable(bit_sel)));
endmodule

// File: tb/cfg_stream_master_tb_top.sv
module cfg_stream_master_tb_top;
   localparam int POR  = 40;
   localparam int HALF = 4;
   localparam int TOT  = 44;
   localparam int AW   = 3;

   logic clk   = 1'b0;
   logic por_n = 1'b0;
   logic oe    = 1'b1;
   logic cs_n  = 1'b0;

   logic [AW-1:0] addr_a, addr_b;
   logic [7:0]    rdata_a, rdata_b;
   logic dclk_a, dat_a, doe_a, casc_a;
   logic dclk_b, dat_b, doe_b, casc_b;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   function automatic logic [7:0] mem_byte(input int a);
      return 8'((a * 37 + 91) & 255);
   endfunction

   assign rdata_a = mem_byte(int'(addr_a));
   assign rdata_b = mem_byte(int'(addr_b));

   cfg_stream_master #(.POR_CYCLES(POR), .HALF_CYC(HALF), .TOTAL_BITS(TOT),
                       .ADDR_W(AW), .PARK_HIGH(1'b0)) dut_i (
      .clk(clk), .por_n(por_n), .oe(oe), .cs_n(cs_n),
      .mem_addr(addr_a), .mem_rdata(rdata_a),
      .dclk(dclk_a), .data_out(dat_a), .data_oe(doe_a), .casc_n(casc_a));

   cfg_stream_master #(.POR_CYCLES(POR), .HALF_CYC(HALF), .TOTAL_BITS(TOT),
                       .ADDR_W(AW), .PARK_HIGH(1'b1)) dut_hi_i (
      .clk(clk), .por_n(por_n), .oe(oe), .cs_n(cs_n),
      .mem_addr(addr_b), .mem_rdata(rdata_b),
      .dclk(dclk_b), .data_out(dat_b), .data_oe(doe_b), .casc_n(casc_b));

   // Edge collector, sampled away from the active clock edge
   int   rise_cnt = 0, fall_cnt = 0, bad_oe_edges = 0;
   int   width_bad = 0, arm_edges = 0, gap = 0, casc_idx = -1;
   logic bits [0:511];
   logic dclk_prev = 1'b0, oe_prev = 1'b0, casc_prev = 1'b1;
   logic chk_width = 1'b0;

   always @(negedge clk) begin
      gap = gap + 1;
      if (dclk_a != dclk_prev) begin
         if (chk_width) begin
            if (arm_edges > 0 && gap != HALF) width_bad = width_bad + 1;
            arm_edges = arm_edges + 1;
         end
         gap = 0;
         if (dclk_a) begin
            if (!oe_prev) bad_oe_edges = bad_oe_edges + 1;
            if (rise_cnt < 512) bits[rise_cnt] = dat_a;
            rise_cnt = rise_cnt + 1;
         end else begin
            fall_cnt = fall_cnt + 1;
         end
      end
      if (!chk_width) arm_edges = 0;
      if (!casc_a && casc_prev) casc_idx = rise_cnt;
      dclk_prev = dclk_a;
      oe_prev   = oe;
      casc_prev = casc_a;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_bits(input int base, input string req);
      int bad = 0;
      for (int k = 0; k < TOT; k++) begin
         logic [7:0] b = mem_byte(k / 8);
         if (bits[base + k] !== b[7 - (k % 8)]) bad++;
      end
      chk(bad == 0, req, "stream bits mismatching memory MSB-first", bad, 0);
   endtask

   task automatic wait_done(input string req);
      int t = 0;
      while (casc_a && t < 2000) begin
         @(posedge clk);
         t++;
      end
      chk(t < 2000, req, "handoff reached", t, 0);
      repeat (HALF + 3) @(posedge clk);
      #1;
   endtask

   task automatic restart();
      @(posedge clk); #1 oe = 1'b0;
      repeat (5) @(posedge clk);
      #1 oe = 1'b1;
   endtask

   // Power-up, one full stream, handoff point, phase widths and parking
   task automatic t_powerup();
      int base;
      repeat (3) @(negedge clk);
      chk(dclk_a == 0 && doe_a == 0 && casc_a == 1, "R1", "reset pin state",
          {dclk_a, doe_a, casc_a}, 3'b001);
      chk_width = 1'b1;
      base = rise_cnt;
      @(posedge clk); #1 por_n = 1'b1;
      repeat (POR) @(posedge clk);
      chk(rise_cnt == base, "R1", "rises during power-on wait", rise_cnt - base, 0);
      repeat (HALF + 6) @(posedge clk);
      chk(rise_cnt > base, "R1", "stream started after wait", rise_cnt - base, 1);
      wait_done("R8");
      chk_width = 1'b0;
      chk(rise_cnt - base == TOT, "R4", "rise count", rise_cnt - base, TOT);
      check_bits(base, "R4");
      chk(casc_idx == base + TOT, "R8", "handoff rise index", casc_idx - base, TOT);
      chk(width_bad == 0, "R3", "phase width violations", width_bad, 0);
      @(negedge clk);
      chk(dclk_a == 0 && doe_a == 0 && casc_a == 0, "R9", "parked pins, float variant",
          {dclk_a, doe_a, casc_a}, 3'b000);
      chk(dclk_b == 0 && doe_b == 1 && dat_b == 1 && casc_b == 0, "R9",
          "parked pins, drive-high variant", {dclk_b, doe_b, dat_b, casc_b}, 4'b0110);
      base = rise_cnt;
      repeat (30) @(posedge clk);
      chk(rise_cnt == base, "R9", "edges after completion", rise_cnt - base, 0);
   endtask

   // Output-enable reset: quick restart, mid-stream reset, counter rewind
   task automatic t_oe_reset();
      int b, t, bad0;
      @(posedge clk); #1 oe = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(dclk_a == 0 && casc_a == 1 && doe_a == 0, "R6", "pins after oe low",
          {dclk_a, casc_a, doe_a}, 3'b010);
      repeat (20) @(posedge clk);
      b = rise_cnt;
      #1 oe = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(doe_a == 1, "R5", "data enable after start", doe_a, 1);
      t = 1;
      while (rise_cnt == b && t < HALF + 4) begin
         @(posedge clk);
         t++;
      end
      chk(rise_cnt > b, "R2", "first rise without power-on wait", t, HALF + 2);
      while (rise_cnt < b + 10) @(posedge clk);
      bad0 = bad_oe_edges;
      #1 oe = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(dclk_a == 0, "R6", "dclk one cycle after oe low", dclk_a, 0);
      b = rise_cnt;
      repeat (30) @(posedge clk);
      chk(rise_cnt == b && bad_oe_edges == bad0, "R6", "rises while oe low",
          rise_cnt - b, 0);
      #1 oe = 1'b1;
      wait_done("R6");
      chk(rise_cnt - b == TOT, "R6", "full restart rise count", rise_cnt - b, TOT);
      check_bits(b, "R6");
   endtask

   // Chip-select pause keeps level and position
   task automatic t_pause();
      int b, rc, fc;
      logic lvl;
      restart();
      b = rise_cnt;
      while (rise_cnt < b + 13) @(posedge clk);
      #1 cs_n = 1'b1;
      @(negedge clk);
      lvl = dclk_a;
      rc  = rise_cnt;
      fc  = fall_cnt;
      repeat (30) @(negedge clk);
      chk(dclk_a == lvl && rise_cnt == rc && fall_cnt == fc, "R7",
          "edges during pause", (rise_cnt - rc) + (fall_cnt - fc), 0);
      @(posedge clk); #1 cs_n = 1'b0;
      wait_done("R7");
      chk(rise_cnt - b == TOT, "R7", "rise count across pause", rise_cnt - b, TOT);
      check_bits(b, "R7");
   endtask

   // Output-enable reset landing on the final rising edge
   task automatic t_collide();
      int b, fb, ci;
      restart();
      b  = rise_cnt;
      fb = fall_cnt;
      ci = casc_idx;
      while (fall_cnt - fb < TOT - 1) @(posedge clk);
      repeat (HALF - 2) @(posedge clk);
      #1 oe = 1'b0;
      repeat (10) @(negedge clk);
      chk(rise_cnt - b == TOT - 1, "R10", "final rise suppressed", rise_cnt - b, TOT - 1);
      chk(casc_a == 1 && casc_b == 1 && casc_idx == ci, "R10", "handoff stays off",
          {casc_a, casc_b}, 2'b11);
      chk(dclk_a == 0, "R10", "dclk low after collision", dclk_a, 0);
      chk(bad_oe_edges == 0, "R6", "rising edges seen with oe low", bad_oe_edges, 0);
   endtask

   initial begin
      t_powerup();
      t_oe_reset();
      t_pause();
      t_collide();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule